// File: doc/BRIEF.md
# SPI TPM Register Transaction Master

This block carries out one register read or register write at a time to a TPM-class device on a SPI bus. A request gives the direction, a byte count from 1 to 64 and a 24-bit register address. The block pulls chip select low and sends a four-byte header. The first header byte carries the direction and the length. The other three bytes carry the address.

The device can stall the transfer with a wait bit, which it returns on MISO in the last bit of the header. While the device is stalled, the block keeps clocking single dummy bytes until the device signals ready. After that it moves the payload. Write bytes are taken from a byte-wide valid/ready source. Read bytes are handed to a byte-wide valid/ready sink. A one-cycle completion pulse reports success or failure. If the device stays stalled past a timeout, the transaction is abandoned and chip select is released. A failed read still hands over its full byte count, every byte zero.

Before the first access after reset, and before any access that follows a long quiet period, the block sends a chip-select wake pulse so that a sleeping device is ready for the transaction. All delays are parameters counted in clock cycles. SCK is the system clock divided down, and the bus runs in SPI mode 0, MSB first.

Top module: `spi_tpm_xfer_master`

## Requirements
- R1: The first header byte is {bit7 = 1 for read / 0 for write, bit6 = 1, bits5:0 = length minus one}.
- R2: Lengths 1 and 64 are both carried, as 0 and 63 in the length field. A request length outside 1..64 is not allowed.
- R3: Header bytes two to four carry address bits 23:16, 15:8 and 7:0, in that order.
- R4: Chip select stays low in one unbroken window from before the first header bit to after the last payload bit. SCK is low whenever chip select is high.
- R5: When bit 0 of the byte received during the fourth header byte is 1, the first payload byte is the fifth byte of the window.
- R6: When that bit is 0, further single bytes are clocked until one arrives with bit 0 set. The payload follows directly after that byte.
- R7: When a polled byte ends with bit 0 clear and at least POLL_TIMEOUT_CYC cycles have passed since polling began, chip select is released and the completion pulse reports an error.
- R8: The first request after reset, and any request that arrives after at least IDLE_SLEEP_CYC idle cycles, is preceded by chip select low for exactly WAKE_LOW_CYC cycles with no SCK, then high for exactly WAKE_HIGH_CYC cycles. Other requests get no wake pulse.
- R9: A failed read still delivers its full byte count on the read interface, each byte 0x00.
- R10: MOSI changes only while SCK is low. MISO is sampled on the rising SCK edge. Bits go most significant first.
- R11: Write payload bytes are taken one per txValid/txReady handshake and sent in order. Read payload bytes are offered on rxData with rxValid and held until rxReady, in the order received.
- R12: Each accepted request ends in exactly one one-cycle doneValid pulse, with doneErr set only on failure. reqReady is high only when no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqRead | input | 1 | 1 = register read, 0 = register write |
| reqLen | input | 7 | Payload length in bytes, 1..64 |
| reqAddr | input | 24 | Device register address |
| txValid | input | 1 | Write payload byte available |
| txReady | output | 1 | Block takes the write byte this cycle |
| txData | input | 8 | Write payload byte |
| rxValid | output | 1 | Read payload byte available |
| rxReady | input | 1 | Consumer takes the read byte |
| rxData | output | 8 | Read payload byte |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Completion carried a wait-state timeout |
| spiCsN | output | 1 | Chip select, active low |
| spiSck | output | 1 | Serial clock, idle low |
| spiMosi | output | 1 | Serial data to device |
| spiMiso | input | 1 | Serial data from device |

## Verification
The assertions take for granted that reqLen lies between 1 and 64 whenever reqValid is high, and that the device changes MISO only after a rising SCK edge. The bench keeps to both. Every request it issues uses a length in that range. Its device model updates MISO one system-clock half period after the edge it observes, and from the byte and bit position it has counted itself. The stimulus throttles txValid and rxReady in regular gaps, so the handshakes are exercised under back-pressure without ever presenting an illegal request.

// File: rtl/spitx_pkg.sv
package spitx_pkg;

  localparam int HDR_BYTES = 4;
  localparam int MAX_LEN   = 64;

  // strobe bundle from control to the shift datapath
  typedef struct packed {
    logic       start;
    logic [7:0] txByte;
  } shiftCmdT;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE_LO,
    ST_WAKE_HI,
    ST_HDR,
    ST_POLL,
    ST_WR_WAIT,
    ST_WR_SHIFT,
    ST_RD_SHIFT,
    ST_RD_PUSH,
    ST_FAIL,
    ST_ZERO_FILL,
    ST_FINISH
  } xferStateT;

endpackage

// File: rtl/spitx_shift.sv
module spitx_shift
  import spitx_pkg::*;
#(
  parameter int SCK_HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  shiftCmdT   cmd,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byteDone,
  output logic [7:0] rxByte
);

  localparam int DW = (SCK_HALF_CYC > 1) ? $clog2(SCK_HALF_CYC) : 1;

  logic [DW-1:0] divCnt;
  logic [2:0]    bitCnt;
  logic [7:0]    shReg;
  logic [7:0]    rxReg;
  logic          busy;
  logic          sckQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      bitCnt   <= '0;
      shReg    <= '0;
      rxReg    <= '0;
      busy     <= 1'b0;
      sckQ     <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (cmd.start) begin
        shReg  <= cmd.txByte;
        busy   <= 1'b1;
        sckQ   <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (busy) begin
        if (divCnt == DW'(SCK_HALF_CYC - 1)) begin
          divCnt <= '0;
          if (!sckQ) begin
            // rising edge: capture device bit
            sckQ  <= 1'b1;
            rxReg <= {rxReg[6:0], miso};
          end else begin
            // falling edge: advance to next outgoing bit
            sckQ <= 1'b0;
            if (bitCnt == 3'd7) begin
              busy     <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              shReg  <= {shReg[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DW'(1);
        end
      end
    end
  end

  assign sck    = sckQ;
  assign mosi   = shReg[7];
  assign rxByte = rxReg;

  // control must only launch a byte into an idle shifter
  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.start |-> !busy);

  // data toward the device never moves on a rising SCK edge
  assert_mosi_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi));

endmodule

// File: rtl/spitx_ctrl.sv
module spitx_ctrl
  import spitx_pkg::*;
#(
  parameter int WAKE_LOW_CYC     = 50,
  parameter int WAKE_HIGH_CYC    = 5000,
  parameter int POLL_TIMEOUT_CYC = 5000000,
  parameter int IDLE_SLEEP_CYC   = 45000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqRead,
  input  logic [6:0]  reqLen,
  input  logic [23:0] reqAddr,
  input  logic        txValid,
  output logic        txReady,
  input  logic [7:0]  txData,
  output logic        rxValid,
  input  logic        rxReady,
  output logic [7:0]  rxData,
  output logic        doneValid,
  output logic        doneErr,
  output logic        spiCsN,
  output shiftCmdT    cmd,
  input  logic        byteDone,
  input  logic [7:0]  rxByte
);

  localparam int TMAX_A = (WAKE_LOW_CYC > WAKE_HIGH_CYC) ? WAKE_LOW_CYC : WAKE_HIGH_CYC;
  localparam int TMAX   = (TMAX_A > POLL_TIMEOUT_CYC) ? TMAX_A : POLL_TIMEOUT_CYC;
  localparam int TW     = $clog2(TMAX + 2);
  localparam int IW     = $clog2(IDLE_SLEEP_CYC + 2);

  xferStateT   state, nxt;
  logic [TW-1:0] timer;
  logic [IW-1:0] idleCnt;
  logic          firstAcc;
  logic          isRead;
  logic [5:0]    lenM1;
  logic [23:0]   addrQ;
  logic [1:0]    hdrIdx;
  logic [6:0]    dataCnt;
  logic [7:0]    rxHold;
  logic          errFlag;

  logic [5:0] lenM1Req;
  logic       needWake;
  logic       lastByte;
  logic [7:0] nextHdr;

  assign lenM1Req = 6'(reqLen - 7'd1);
  assign needWake = firstAcc || (idleCnt == IW'(IDLE_SLEEP_CYC));
  assign lastByte = (dataCnt == {1'b0, lenM1});

  always_comb begin
    case (hdrIdx)
      2'd0:    nextHdr = addrQ[23:16];
      2'd1:    nextHdr = addrQ[15:8];
      default: nextHdr = addrQ[7:0];
    endcase
  end

  always_comb begin
    nxt        = state;
    cmd        = '0;
    reqReady   = 1'b0;
    txReady    = 1'b0;
    rxValid    = 1'b0;
    doneValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (needWake) nxt = ST_WAKE_LO;
          else begin
            nxt        = ST_HDR;
            cmd.start  = 1'b1;
            cmd.txByte = {reqRead, 1'b1, lenM1Req};
          end
        end
      end
      ST_WAKE_LO: if (timer == TW'(WAKE_LOW_CYC - 1)) nxt = ST_WAKE_HI;
      ST_WAKE_HI: if (timer == TW'(WAKE_HIGH_CYC - 1)) begin
        nxt        = ST_HDR;
        cmd.start  = 1'b1;
        cmd.txByte = {isRead, 1'b1, lenM1};
      end
      ST_HDR, ST_POLL: if (byteDone) begin
        if (state == ST_HDR && hdrIdx != 2'd3) begin
          cmd.start  = 1'b1;
          cmd.txByte = nextHdr;
        end else if (rxByte[0]) begin
          if (isRead) begin
            nxt       = ST_RD_SHIFT;
            cmd.start = 1'b1;
          end else nxt = ST_WR_WAIT;
        end else if (state == ST_POLL && timer >= TW'(POLL_TIMEOUT_CYC)) begin
          nxt = ST_FAIL;
        end else begin
          nxt       = ST_POLL;
          cmd.start = 1'b1;
        end
      end
      ST_WR_WAIT: begin
        txReady = 1'b1;
        if (txValid) begin
          nxt        = ST_WR_SHIFT;
          cmd.start  = 1'b1;
          cmd.txByte = txData;
        end
      end
      ST_WR_SHIFT: if (byteDone) nxt = lastByte ? ST_FINISH : ST_WR_WAIT;
      ST_RD_SHIFT: if (byteDone) nxt = ST_RD_PUSH;
      ST_RD_PUSH: begin
        rxValid = 1'b1;
        if (rxReady) begin
          if (lastByte) nxt = ST_FINISH;
          else begin
            nxt       = ST_RD_SHIFT;
            cmd.start = 1'b1;
          end
        end
      end
      ST_FAIL: nxt = isRead ? ST_ZERO_FILL : ST_FINISH;
      ST_ZERO_FILL: begin
        rxValid = 1'b1;
        if (rxReady && lastByte) nxt = ST_FINISH;
      end
      ST_FINISH: begin
        doneValid = 1'b1;
        nxt       = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      idleCnt  <= '0;
      firstAcc <= 1'b1;
      isRead   <= 1'b0;
      lenM1    <= '0;
      addrQ    <= '0;
      hdrIdx   <= '0;
      dataCnt  <= '0;
      rxHold   <= '0;
      errFlag  <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state)            timer <= '0;
      else if (timer != TW'(TMAX + 1)) timer <= timer + TW'(1);

      if (state != ST_IDLE)                     idleCnt <= '0;
      else if (idleCnt != IW'(IDLE_SLEEP_CYC))  idleCnt <= idleCnt + IW'(1);

      if (state == ST_IDLE && reqValid) begin
        isRead   <= reqRead;
        lenM1    <= lenM1Req;
        addrQ    <= reqAddr;
        firstAcc <= 1'b0;
        errFlag  <= 1'b0;
        dataCnt  <= '0;
        hdrIdx   <= '0;
      end

      if (state == ST_HDR && byteDone && hdrIdx != 2'd3) hdrIdx <= hdrIdx + 2'd1;

      if ((state == ST_WR_SHIFT && byteDone) ||
          ((state == ST_RD_PUSH || state == ST_ZERO_FILL) && rxReady))
        dataCnt <= dataCnt + 7'd1;

      if (state == ST_RD_SHIFT && byteDone) rxHold <= rxByte;
      if (state == ST_FAIL) begin
        rxHold  <= 8'h00;
        errFlag <= 1'b1;
      end
    end
  end

  assign rxData  = rxHold;
  assign doneErr = errFlag;

  always_comb begin
    case (state)
      ST_WAKE_LO, ST_HDR, ST_POLL, ST_WR_WAIT, ST_WR_SHIFT,
      ST_RD_SHIFT, ST_RD_PUSH: spiCsN = 1'b0;
      default:                 spiCsN = 1'b1;
    endcase
  end

  // input assumption: only lengths 1..64 are requested
  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> (reqLen >= 7'd1 && reqLen <= 7'd64));

  // a failed read only ever hands zero bytes to the consumer
  assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && errFlag) |-> (rxData == 8'h00));

  // write payload is only requested on write transactions
  assert_tx_write_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> !isRead);

  // completion is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

// File: rtl/spi_tpm_xfer_master.sv
module spi_tpm_xfer_master
  import spitx_pkg::*;
#(
  parameter int SCK_HALF_CYC     = 2,
  parameter int WAKE_LOW_CYC     = 50,
  parameter int WAKE_HIGH_CYC    = 5000,
  parameter int POLL_TIMEOUT_CYC = 5000000,
  parameter int IDLE_SLEEP_CYC   = 45000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqRead,
  input  logic [6:0]  reqLen,
  input  logic [23:0] reqAddr,
  input  logic        txValid,
  output logic        txReady,
  input  logic [7:0]  txData,
  output logic        rxValid,
  input  logic        rxReady,
  output logic [7:0]  rxData,
  output logic        doneValid,
  output logic        doneErr,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso
);

  shiftCmdT   cmd;
  logic       byteDone;
  logic [7:0] rxByte;

  spitx_ctrl #(
    .WAKE_LOW_CYC    (WAKE_LOW_CYC),
    .WAKE_HIGH_CYC   (WAKE_HIGH_CYC),
    .POLL_TIMEOUT_CYC(POLL_TIMEOUT_CYC),
    .IDLE_SLEEP_CYC  (IDLE_SLEEP_CYC)
  ) uCtrl (
    .clk, .rstN,
    .reqValid, .reqReady, .reqRead, .reqLen, .reqAddr,
    .txValid, .txReady, .txData,
    .rxValid, .rxReady, .rxData,
    .doneValid, .doneErr, .spiCsN,
    .cmd, .byteDone, .rxByte
  );

  spitx_shift #(
    .SCK_HALF_CYC(SCK_HALF_CYC)
  ) uShift (
    .clk, .rstN, .cmd,
    .miso    (spiMiso),
    .sck     (spiSck),
    .mosi    (spiMosi),
    .byteDone,
    .rxByte
  );

  // bus is quiet whenever the device is deselected
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSck);

endmodule

// File: tb/sim_spi_tpm_xfer_master.sv
module sim_spi_tpm_xfer_master;

  localparam int HALF = 2;
  localparam int WLO  = 10;
  localparam int WHI  = 40;
  localparam int PTO  = 300;
  localparam int IDL  = 2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqRead = 1'b0;
  logic [6:0]  reqLen = 7'd1;
  logic [23:0] reqAddr = '0;
  logic        txValid = 1'b0;
  logic        txReady;
  logic [7:0]  txData = '0;
  logic        rxValid;
  logic        rxReady = 1'b1;
  logic [7:0]  rxData;
  logic        doneValid;
  logic        doneErr;
  logic        spiCsN;
  logic        spiSck;
  logic        spiMosi;
  logic        spiMiso = 1'b0;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;

  spi_tpm_xfer_master #(
    .SCK_HALF_CYC(HALF), .WAKE_LOW_CYC(WLO), .WAKE_HIGH_CYC(WHI),
    .POLL_TIMEOUT_CYC(PTO), .IDLE_SLEEP_CYC(IDL)
  ) u0 (
    .clk, .rstN, .reqValid, .reqReady, .reqRead, .reqLen, .reqAddr,
    .txValid, .txReady, .txData, .rxValid, .rxReady, .rxData,
    .doneValid, .doneErr, .spiCsN, .spiSck, .spiMosi, .spiMiso
  );

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural device model ----------------
  logic [7:0] rdMem [64];
  logic [7:0] wrMem [64];
  int nPoll = 0;
  int byteIdx = 0, bitIdx = 0;
  logic [7:0] shIn = '0;
  logic [7:0] winBytes[$];
  logic [7:0] lastWin[$];
  int lowCnt = 0, highCnt = 0, lastWakeLow = 0, lastHighGap = 0, wakeCount = 0;
  logic prevSck = 1'b0, prevCs = 1'b1;

  function automatic logic [7:0] misoByte(input int idx, input int np);
    if (idx < 3) return 8'h5A;
    if (idx == 3) return (np == 0) ? 8'hC3 : 8'hC2;
    if (idx < 4 + np) return (idx == 3 + np) ? 8'h81 : 8'h80;
    return rdMem[(idx - 4 - np) & 63];
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (spiCsN && spiSck) begin
        errs++;
        $display("FAIL R4: got sck %0b expected 0 while deselected", spiSck);
      end
    end
    if (!spiCsN) begin
      if (prevCs) begin
        lastHighGap = highCnt;
        highCnt = 0;
      end
      lowCnt++;
      if (!prevSck && spiSck) begin
        shIn = {shIn[6:0], spiMosi};
        if (bitIdx == 7) begin
          winBytes.push_back(shIn);
          bitIdx = 0;
          byteIdx++;
        end else bitIdx++;
      end
    end else begin
      if (!prevCs) begin
        lastWin = winBytes;
        if (winBytes.size() == 0) begin
          wakeCount++;
          lastWakeLow = lowCnt;
        end
        winBytes.delete();
      end
      lowCnt = 0;
      highCnt++;
      bitIdx = 0;
      byteIdx = 0;
    end
    prevSck = spiSck;
    prevCs  = spiCsN;
    spiMiso = misoByte(byteIdx, nPoll)[7 - bitIdx];
  end

  // ---------------- transaction driver and checker ----------------
  task automatic runTxn(input bit rd, input int len, input logic [23:0] addr,
                        input int polls, input int expWake, input bit expErr);
    int txIdx = 0;
    int cyc = 0;
    bit reqFire = 0, txFire = 0, finished = 0, gotErr = 0;
    int wakeBefore;
    logic [7:0] got[$];
    logic [7:0] hdr0;
    nPoll = polls;
    for (int i = 0; i < 64; i++) begin
      rdMem[i] = 8'(addr[7:0] + 8'(i * 13) + 8'd1);
      wrMem[i] = 8'(addr[15:8] ^ 8'(i * 29) ^ 8'h3C);
    end
    wakeBefore = wakeCount;
    @(negedge clk);
    reqRead = rd; reqLen = 7'(len); reqAddr = addr; reqValid = 1'b1;
    while (!finished && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (reqFire) reqValid = 1'b0;
      if (txFire) txIdx++;
      rxReady = (cyc % 3 != 0);
      txValid = !rd && (txIdx < len) && (cyc % 4 != 1);
      txData  = (txIdx < len) ? wrMem[txIdx & 63] : 8'h00;
      reqFire = reqValid && reqReady;
      txFire  = txValid && txReady;
      if (rxValid && rxReady) got.push_back(rxData);
      if (doneValid) begin
        finished = 1;
        gotErr = doneErr;
      end
    end
    reqValid = 1'b0; txValid = 1'b0; rxReady = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 completion seen", finished, 1);
    check("R12 error flag", gotErr, expErr);
    check("R8 wake pulses", wakeCount - wakeBefore, expWake);
    if (expWake != 0) begin
      check("R8 wake low length", lastWakeLow, WLO);
      check("R8 wake high gap", lastHighGap, WHI);
    end
    hdr0 = {rd, 1'b1, 6'(len - 1)};
    check("R1 header byte 0", lastWin.size() > 0 ? lastWin[0] : 8'hxx, hdr0);
    check("R3 address high", lastWin.size() > 1 ? lastWin[1] : 8'hxx, addr[23:16]);
    check("R3 address mid", lastWin.size() > 2 ? lastWin[2] : 8'hxx, addr[15:8]);
    check("R3 address low", lastWin.size() > 3 ? lastWin[3] : 8'hxx, addr[7:0]);
    if (!expErr) begin
      check("R4 R5 R6 window byte count", lastWin.size(), 4 + polls + len);
      if (!rd) begin
        for (int i = 0; i < len; i++)
          check("R11 write payload byte", lastWin[4 + polls + i], wrMem[i]);
        check("R11 nothing delivered on write", got.size(), 0);
      end else begin
        check("R11 read byte count", got.size(), len);
        for (int i = 0; i < len && i < got.size(); i++)
          check("R10 R11 read payload byte", got[i], rdMem[i]);
      end
    end else begin
      checks++;
      if (lastWin.size() < 13 || lastWin.size() > 15) begin
        errs++;
        $display("FAIL R7: got window %0d bytes expected 13..15", lastWin.size());
      end
      check("R7 chip select released", spiCsN, 1);
      if (rd) begin
        check("R9 zero byte count", got.size(), len);
        for (int i = 0; i < got.size(); i++)
          check("R9 zero fill byte", got[i], 0);
      end else check("R7 no read data on write", got.size(), 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 reset chip select", spiCsN, 1);
    check("R4 reset sck", spiSck, 0);
    check("R12 reset reqReady", reqReady, 1);
    check("R12 reset doneValid", doneValid, 0);
    check("R11 reset rxValid", rxValid, 0);
    check("R11 reset txReady", txReady, 0);

    runTxn(1'b0, 4,  24'hD40018, 0, 1, 1'b0);   // first access: wake
    runTxn(1'b1, 4,  24'hD40F00, 0, 0, 1'b0);   // back-to-back: no wake
    runTxn(1'b1, 1,  24'h000024, 3, 0, 1'b0);   // R2 minimum length, R6 polling
    runTxn(1'b0, 64, 24'hABCDEF, 1, 0, 1'b0);   // R2 maximum length write
    runTxn(1'b1, 64, 24'h123456, 0, 0, 1'b0);   // R2 maximum length read
    repeat (2600) @(negedge clk);
    runTxn(1'b1, 2,  24'h00F904, 2, 1, 1'b0);   // R8 wake after long idle
    runTxn(1'b1, 5,  24'h770024, 100000, 0, 1'b1); // R7 R9 read timeout
    runTxn(1'b0, 3,  24'h770018, 100000, 0, 1'b1); // R7 write timeout
    runTxn(1'b1, 3,  24'h3300AA, 0, 0, 1'b0);   // recovery after failure

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL R12: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule